// File: doc/BRIEF.md
# PS/2 keyboard byte receiver

This block takes the clock and data lines of a PS/2 keyboard and turns each eleven-bit frame into one parallel byte. Both lines are brought into the system clock domain through flop synchronizers. A falling-edge detector on the synchronized keyboard clock decides when each bit is sampled. Once a frame has been checked, the byte is shown on an 8-bit output and a ready flag goes high. The ready flag is meant to drive an edge-sensitive interrupt input of a host peripheral port.

The byte and the ready flag hold until the host pulses the clear input. While ready is high, keyboard traffic is not taken in. Clear empties the register and reopens the receiver for the next key event. A frame whose parity or stop bit is wrong is dropped without a ready pulse. A half-received frame is abandoned when the keyboard clock stays quiet for the idle limit, which is about 2 ms by default.

Top module: `ps2_kbd_rx`

## Requirements
- R1: After reset, `kbd_ready_o` is 0 and `kbd_byte_o` is 0x00.
- R2: A frame sampled on successive keyboard-clock falling edges is accepted when it carries a start bit of 0, eight data bits least significant first, a parity bit that makes the count of ones across data and parity odd, and a stop bit of 1. When a frame is accepted, its data byte appears on `kbd_byte_o` and `kbd_ready_o` goes high within a few system cycles of the stop-bit falling edge.
- R3: While `kbd_ready_o` is high and `kbd_clr_i` is low, the ready flag and the byte stay unchanged. Any further frames are ignored.
- R4: When `kbd_clr_i` is high at a clock edge, the next cycle shows `kbd_ready_o` at 0 and `kbd_byte_o` at 0x00. After that, the next frame is received normally.
- R5: A frame with wrong parity is discarded, and `kbd_ready_o` stays 0.
- R6: A frame whose stop bit is 0 is discarded, and `kbd_ready_o` stays 0.
- R7: A keyboard-clock falling edge with data high, seen while no frame is in progress, does not start a frame.
- R8: If a frame is in progress and no keyboard-clock falling edge arrives for `TIMEOUT_CYC` system cycles, the partial frame is dropped. The next complete frame then decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| kbd_clr_i | input | 1 | Host clear: empties the register and rearms the receiver |
| kbd_byte_o | output | 8 | Last accepted keyboard byte |
| kbd_ready_o | output | 1 | High while a received byte waits for the host |

## Verification
The bench first walks a table of good frames, frames with flipped parity and frames with a zero stop bit. Data values include 0x00 and 0xFF, so the parity rule with all-zero and all-one data is exercised. A receiver that computes even parity, or shifts bits most significant first, shows the wrong byte or raises ready on a bad frame.

Directed tests then cover the remaining corner cases:
- A second frame sent while ready is high. A design that overwrites the held byte is caught here.
- A stray falling edge with data high. A design that takes it as a start bit decodes the following frame shifted by one bit.
- A partial frame followed by a long idle gap. A design with no idle timeout folds the leftover bits into the next frame and shows a corrupted byte.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int KBD_W      = 8;
  localparam int FRAME_BITS = KBD_W + 3;            // start, data, parity, stop
  localparam int CNT_W      = $clog2(FRAME_BITS);

  // Odd parity: data ones plus parity bit must be an odd count.
  function automatic logic parity_odd_ok(input logic [KBD_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  // Bits arrive least significant first: new bit enters at the top.
  function automatic logic [KBD_W-1:0] shift_lsb_first(input logic [KBD_W-1:0] sr, input logic b);
    return {b, sr[KBD_W-1:1]};
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic dat_s,
  output logic clk_fall
);
  logic [STAGES-1:0] clk_sh;
  logic [STAGES-1:0] dat_sh;
  logic              clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh   <= '1;
      dat_sh   <= '1;
      clk_prev <= 1'b1;
    end else begin
      clk_sh   <= {clk_sh[STAGES-2:0], ps2_clk_i};
      dat_sh   <= {dat_sh[STAGES-2:0], ps2_dat_i};
      clk_prev <= clk_sh[STAGES-1];
    end
  end

  assign dat_s    = dat_sh[STAGES-1];
  assign clk_fall = clk_prev & ~clk_sh[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fall |=> !clk_fall);                                        // R2
endmodule

// File: rtl/ps2_idle_timer.sv
module ps2_idle_timer #(
  parameter int LIMIT = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic clk_fall,
  output logic idle_abort
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!busy || clk_fall) idle_cnt <= '0;
    else if (idle_cnt != LAST)  idle_cnt <= idle_cnt + 1'b1;
  end

  assign idle_abort = busy && !clk_fall && (idle_cnt == LAST);

  AST_IDLE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= LAST);                                              // R8
  AST_IDLE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fall |=> idle_cnt == '0);                                   // R8
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_fall,
  input  logic             dat_s,
  input  logic             idle_abort,
  input  logic             clr,
  output logic             busy,
  output logic [KBD_W-1:0] key_byte,
  output logic             key_ready,
  output logic             frame_done,
  output logic             frame_bad
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(KBD_W);
  localparam logic [CNT_W-1:0] PAR_SLOT  = CNT_W'(KBD_W + 1);
  localparam logic [CNT_W-1:0] STOP_SLOT = CNT_W'(KBD_W + 2);

  logic [CNT_W-1:0] bit_cnt;
  logic [KBD_W-1:0] sr;
  logic             par_q;
  logic             at_stop;
  logic             frame_ok;

  assign at_stop    = clk_fall && (bit_cnt == STOP_SLOT) && !idle_abort;
  assign frame_ok   = at_stop && dat_s && parity_odd_ok(sr, par_q);
  assign frame_done = frame_ok && !clr;
  assign frame_bad  = at_stop && !frame_ok && !clr;
  assign busy       = (bit_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      sr        <= '0;
      par_q     <= 1'b0;
      key_byte  <= '0;
      key_ready <= 1'b0;
    end else if (clr) begin
      bit_cnt   <= '0;
      sr        <= '0;
      key_byte  <= '0;
      key_ready <= 1'b0;
    end else if (idle_abort) begin
      bit_cnt <= '0;
    end else if (clk_fall && !key_ready) begin
      if (bit_cnt == '0) begin
        if (!dat_s) bit_cnt <= CNT_W'(1);
      end else if (bit_cnt <= LAST_DATA) begin
        sr      <= shift_lsb_first(sr, dat_s);
        bit_cnt <= bit_cnt + 1'b1;
      end else if (bit_cnt == PAR_SLOT) begin
        par_q   <= dat_s;
        bit_cnt <= bit_cnt + 1'b1;
      end else begin
        bit_cnt <= '0;
        if (frame_ok) begin
          key_byte  <= sr;
          key_ready <= 1'b1;
        end
      end
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!key_ready && key_byte == '0));                        // R4
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ready && !clr) |=> (key_ready && $stable(key_byte)));      // R3
  AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> key_ready);                                      // R2
  AST_BAD_DISCARDED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> !key_ready);                                      // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, frame_bad}));                             // R6
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fall && bit_cnt == '0 && dat_s && !clr && !idle_abort) |=> bit_cnt == '0); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_abort && !clr) |=> bit_cnt == '0);                        // R8
endmodule

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx #(
  parameter int TIMEOUT_CYC = 100_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       kbd_clr_i,
  output logic [7:0] kbd_byte_o,
  output logic       kbd_ready_o
);
  logic dat_s, clk_fall, idle_abort, busy, frame_done, frame_bad;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .dat_s(dat_s), .clk_fall(clk_fall));

  ps2_idle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(busy), .clk_fall(clk_fall),
    .idle_abort(idle_abort));

  ps2_frame_rx u_frame (
    .clk(clk), .rst_n(rst_n), .clk_fall(clk_fall), .dat_s(dat_s),
    .idle_abort(idle_abort), .clr(kbd_clr_i), .busy(busy),
    .key_byte(kbd_byte_o), .key_ready(kbd_ready_o),
    .frame_done(frame_done), .frame_bad(frame_bad));

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $rose(rst_n) |-> (!kbd_ready_o && kbd_byte_o == 8'h00));        // R1
endmodule

// File: tb/ps2_kbd_rx_bench.sv
module ps2_kbd_rx_bench;
  localparam int HALF = 20;     // system cycles per keyboard clock phase
  localparam int TMO  = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps2_clk = 1'b1;
  logic       ps2_dat = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] kbyte;
  logic       kready;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;        // 50 MHz

  ps2_kbd_rx #(.TIMEOUT_CYC(TMO)) u_ps2_kbd_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .kbd_clr_i(clr), .kbd_byte_o(kbyte), .kbd_ready_o(kready));

  // {expected ready, stop bit, flip parity, data byte}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 8'h1C},
    {1'b1, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'hFF},
    {1'b1, 1'b1, 1'b0, 8'hA5},
    {1'b0, 1'b1, 1'b1, 8'h5A},
    {1'b0, 1'b0, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'h80},
    {1'b0, 1'b1, 1'b1, 8'h01}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ready/byte actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) ps2_dat = b;
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit((~^d) ^ flip);
    send_bit(stop);
    ps2_dat = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {kready, kbyte}, 9'h000);

    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v][7:0], VEC[v][8], VEC[v][9]);
      check(VEC[v][10] ? "R2 accepted frame" : (VEC[v][9] ? "R5 parity reject" : "R6 stop reject"),
            {kready, kbyte}, {VEC[v][10], VEC[v][10] ? VEC[v][7:0] : 8'h00});
      pulse_clr();
      check("R4 clear empties", {kready, kbyte}, 9'h000);
    end

    // R3: held byte survives a later frame
    send_frame(8'h2A, 1'b0, 1'b1);
    check("R2 first held", {kready, kbyte}, {1'b1, 8'h2A});
    send_frame(8'h77, 1'b0, 1'b1);
    check("R3 ignored while ready", {kready, kbyte}, {1'b1, 8'h2A});
    pulse_clr();
    check("R4 clear after hold", {kready, kbyte}, 9'h000);
    send_frame(8'h77, 1'b0, 1'b1);
    check("R4 resumes after clear", {kready, kbyte}, {1'b1, 8'h77});
    pulse_clr();

    // R7: stray falling edge with data high
    send_bit(1'b1);
    repeat (4) @(negedge clk);
    check("R7 stray edge no ready", {kready, kbyte}, 9'h000);
    send_frame(8'h66, 1'b0, 1'b1);
    check("R7 frame after stray edge", {kready, kbyte}, {1'b1, 8'h66});
    pulse_clr();

    // R8: partial frame then idle gap
    send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    ps2_dat = 1'b1;
    repeat (TMO + 500) @(negedge clk);
    check("R8 partial gives no ready", {kready, kbyte}, 9'h000);
    send_frame(8'h42, 1'b0, 1'b1);
    check("R8 frame after timeout", {kready, kbyte}, {1'b1, 8'h42});
    pulse_clr();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule